// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the processor side of an external coprocessor port and runs the handshake for every instruction that may belong to a coprocessor. Once an instruction is issued, the block pulls its active-low select line down and samples two shared response lines each cycle. The first line says "nobody claims this instruction" when high. The second says "claimed, but not ready yet" when high. From these it takes one of four paths. It raises an undefined-instruction trap when nobody claims the instruction. It waits while the claiming coprocessor is busy, and gives up that wait when an enabled interrupt is pending. It completes a plain operation. For a memory transfer, it steps a word address for as long as the coprocessor keeps accepting words.

A small coprocessor-side responder is built in. It has a fixed 4-bit identity, holds the claim line low only for coprocessor-class instructions whose number field matches, and stays busy for a programmed number of cycles. For transfers it then accepts a programmed number of words and releases both lines to end the transfer. Other coprocessors on the same port take part through two external line inputs, which are wire-ANDed with the responder's outputs. Each outcome is reported as a one-cycle pulse, so a surrounding pipeline can restart an abandoned instruction from its beginning.

Top module: `cpx_handshake_top`

## Requirements
- R1: After reset the block is ready, the select output `cpi_n` is high, and none of the outcome pulses `done`, `trap_undef`, `interrupted` or `proto_err` is asserted.
- R2: An issue accepted while ready drives `cpi_n` low from the next cycle until the cycle in which the outcome pulse appears. In that cycle `cpi_n` is high again and `ready` is 1.
- R3: If both response lines are high in the first handshake cycle, `trap_undef` pulses in the following cycle. This is the case for a class-0 instruction (bit 27 = 0) and for a number field (bits 11:8) that matches no coprocessor.
- R4: While the claim line is low and the busy line is high the block waits. When busy falls, an instruction that is not a transfer (bits 27:25 other than 110) completes, with `done` pulsing one cycle later.
- R5: A pending enabled interrupt (`irq_pend`) during a busy cycle ends the handshake, with `interrupted` pulsing one cycle later and no `done`. If the interrupt arrives only in the cycle where busy has already fallen, the instruction completes normally.
- R6: For a transfer (bits 27:25 = 110), every cycle after acceptance in which both lines are low is one word. `xfer_valid` is 1, `xfer_addr` starts at the issue base and rises by 4 per word, and `xfer_load` equals instruction bit 20. When both lines go high, `done` pulses one cycle later. A transfer of zero words is allowed.
- R7: A transfer in which the coprocessor still asks for a word after MAX_WORDS (16) words gets no further `xfer_valid`. `proto_err` pulses instead of `done`.
- R8: Either line low while the block is idle, or the busy line low while the claim line is high during the wait, makes `proto_err` pulse in the next cycle. In the wait case the handshake ends.
- R9: The responder pulls the claim line low only for bit 27 = 1 with a number field equal to COP_ID. While `cpi_n` is high it holds both of its lines high.
- R10: `issue_valid` has no effect while a handshake is in progress.
- R11: At most one outcome pulse is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | Start a handshake (taken only when ready) |
| issue_instr | input | 32 | Instruction word for the handshake |
| issue_base | input | ADDR_W | Start byte address for a transfer |
| irq_pend | input | 1 | Enabled interrupt pending |
| ext_cpa | input | 1 | Claim line from other coprocessors, high = not claimed |
| ext_cpb | input | 1 | Busy line from other coprocessors, high = busy |
| rsp_busy_cycles | input | CNT_W | Responder: busy cycles before it accepts |
| rsp_words | input | CNT_W | Responder: words it asks for in a transfer |
| ready | output | 1 | Block idle, may take an issue |
| cpi_n | output | 1 | Active-low coprocessor instruction select |
| xfer_valid | output | 1 | One transfer word this cycle |
| xfer_load | output | 1 | Transfer direction, 1 = load |
| xfer_addr | output | ADDR_W | Byte address of the current word |
| done | output | 1 | Pulse: instruction completed |
| trap_undef | output | 1 | Pulse: undefined-instruction trap |
| interrupted | output | 1 | Pulse: wait abandoned for an interrupt |
| proto_err | output | 1 | Pulse: response lines broke the protocol |

## Verification
The bench builds the block with COP_ID = 9, CNT_W = 5 and MAX_WORDS = 16. The narrower responder counters still allow up to 31 busy cycles and 31 requested words. This makes a 20-word burst that overruns the 16-word cap reachable, next to the exact 16-word and zero-word limits. Because the number field 9 is distinct from the values used in the other tests, one mismatching instruction and one class-0 instruction with a matching number both exercise the trap path. The reference model derives each handshake's cycle timeline from the busy count, the word count and the interrupt cycle, and compares every output on every clock.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    localparam int CLASS_BIT  = 27;
    localparam int LOAD_BIT   = 20;
    localparam int NUM_LSB    = 8;
    localparam int NUM_W      = 4;

    function automatic logic is_transfer(input logic [31:0] ins);
        return ins[27:25] == 3'b110;
    endfunction

endpackage

// File: rtl/cpx_seq.sv
module cpx_seq
    import cpx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [31:0]       issue_instr,
    input  logic [ADDR_W-1:0] issue_base,
    input  logic              irq_pend,
    input  logic              line_cpa,
    input  logic              line_cpb,
    output logic              cpi_n,
    output logic              ready,
    output logic              in_xfer,
    output logic              f_cls,
    output logic              f_xfer,
    output logic [NUM_W-1:0]  f_num,
    output logic              xfer_valid,
    output logic              xfer_load,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              done,
    output logic              trap_undef,
    output logic              interrupted,
    output logic              proto_err
);

    localparam int WC_W = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        phase_e            ph;
        logic              cls;
        logic              xfer;
        logic              load;
        logic [NUM_W-1:0]  num;
        logic [ADDR_W-1:0] addr;
        logic [WC_W-1:0]   wcnt;
        logic              done;
        logic              trap;
        logic              intr;
        logic              perr;
    } seq_t;

    seq_t st_d, st_q;
    logic cap_full;

    logic unused_fields;
    assign unused_fields = ^{issue_instr[31:28], issue_instr[24:21],
                             issue_instr[19:12], issue_instr[7:0]};

    assign cap_full = (st_q.wcnt == WC_W'(MAX_WORDS));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.trap = 1'b0;
        st_d.intr = 1'b0;
        st_d.perr = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (!line_cpa || !line_cpb) st_d.perr = 1'b1;
                if (issue_valid) begin
                    st_d.ph   = PH_WAIT;
                    st_d.cls  = issue_instr[CLASS_BIT];
                    st_d.xfer = is_transfer(issue_instr);
                    st_d.load = issue_instr[LOAD_BIT];
                    st_d.num  = issue_instr[NUM_LSB +: NUM_W];
                    st_d.addr = issue_base;
                    st_d.wcnt = '0;
                end
            end
            PH_WAIT: begin
                unique case ({line_cpa, line_cpb})
                    2'b11: begin
                        st_d.trap = 1'b1;
                        st_d.ph   = PH_IDLE;
                    end
                    2'b01: begin
                        if (irq_pend) begin
                            st_d.intr = 1'b1;
                            st_d.ph   = PH_IDLE;
                        end
                    end
                    2'b00: begin
                        if (st_q.xfer) begin
                            st_d.ph = PH_XFER;
                        end else begin
                            st_d.done = 1'b1;
                            st_d.ph   = PH_IDLE;
                        end
                    end
                    default: begin
                        st_d.perr = 1'b1;
                        st_d.ph   = PH_IDLE;
                    end
                endcase
            end
            PH_XFER: begin
                unique case ({line_cpa, line_cpb})
                    2'b11: begin
                        st_d.done = 1'b1;
                        st_d.ph   = PH_IDLE;
                    end
                    2'b00: begin
                        if (cap_full) begin
                            st_d.perr = 1'b1;
                            st_d.ph   = PH_IDLE;
                        end else begin
                            st_d.addr = st_q.addr + ADDR_W'(4);
                            st_d.wcnt = st_q.wcnt + WC_W'(1);
                        end
                    end
                    default: begin
                        st_d.perr = 1'b1;
                        st_d.ph   = PH_IDLE;
                    end
                endcase
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready       = (st_q.ph == PH_IDLE);
    assign cpi_n       = (st_q.ph == PH_IDLE);
    assign in_xfer     = (st_q.ph == PH_XFER);
    assign f_cls       = st_q.cls;
    assign f_xfer      = st_q.xfer;
    assign f_num       = st_q.num;
    assign xfer_valid  = in_xfer && !line_cpa && !line_cpb && !cap_full;
    assign xfer_load   = st_q.load;
    assign xfer_addr   = st_q.addr;
    assign done        = st_q.done;
    assign trap_undef  = st_q.trap;
    assign interrupted = st_q.intr;
    assign proto_err   = st_q.perr;

endmodule

// File: rtl/cpx_responder.sv
module cpx_responder
    import cpx_pkg::*;
#(
    parameter int COP_ID = 5,
    parameter int CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpi_n,
    input  logic             f_cls,
    input  logic             f_xfer,
    input  logic [NUM_W-1:0] f_num,
    input  logic [CNT_W-1:0] busy_cycles,
    input  logic [CNT_W-1:0] xfer_words,
    output logic             rsp_cpa,
    output logic             rsp_cpb
);

    localparam int TW = CNT_W + 2;

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] lim_busy, lim_word;
    logic          match;

    assign match    = !cpi_n && f_cls && (f_num == NUM_W'(COP_ID));
    assign lim_busy = TW'(busy_cycles);
    assign lim_word = lim_busy + (f_xfer ? TW'(xfer_words) : '0);

    always_comb begin
        if (!match)            cnt_d = '0;
        else if (&cnt_q)       cnt_d = cnt_q;
        else                   cnt_d = cnt_q + TW'(1);

        if (!match) begin
            rsp_cpa = 1'b1;
            rsp_cpb = 1'b1;
        end else if (cnt_q < lim_busy) begin
            rsp_cpa = 1'b0;
            rsp_cpb = 1'b1;
        end else if (cnt_q <= lim_word) begin
            rsp_cpa = 1'b0;
            rsp_cpb = 1'b0;
        end else begin
            rsp_cpa = 1'b1;
            rsp_cpb = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cpx_handshake_top.sv
module cpx_handshake_top
    import cpx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = 6,
    parameter int COP_ID    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [31:0]       issue_instr,
    input  logic [ADDR_W-1:0] issue_base,
    input  logic              irq_pend,
    input  logic              ext_cpa,
    input  logic              ext_cpb,
    input  logic [CNT_W-1:0]  rsp_busy_cycles,
    input  logic [CNT_W-1:0]  rsp_words,
    output logic              ready,
    output logic              cpi_n,
    output logic              xfer_valid,
    output logic              xfer_load,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              done,
    output logic              trap_undef,
    output logic              interrupted,
    output logic              proto_err
);

    logic             line_cpa, line_cpb;
    logic             rsp_cpa, rsp_cpb;
    logic             in_xfer;
    logic             f_cls, f_xfer;
    logic [NUM_W-1:0] f_num;

    assign line_cpa = ext_cpa & rsp_cpa;
    assign line_cpb = ext_cpb & rsp_cpb;

    cpx_seq #(
        .ADDR_W    (ADDR_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_instr (issue_instr),
        .issue_base  (issue_base),
        .irq_pend    (irq_pend),
        .line_cpa    (line_cpa),
        .line_cpb    (line_cpb),
        .cpi_n       (cpi_n),
        .ready       (ready),
        .in_xfer     (in_xfer),
        .f_cls       (f_cls),
        .f_xfer      (f_xfer),
        .f_num       (f_num),
        .xfer_valid  (xfer_valid),
        .xfer_load   (xfer_load),
        .xfer_addr   (xfer_addr),
        .done        (done),
        .trap_undef  (trap_undef),
        .interrupted (interrupted),
        .proto_err   (proto_err)
    );

    cpx_responder #(
        .COP_ID (COP_ID),
        .CNT_W  (CNT_W)
    ) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpi_n       (cpi_n),
        .f_cls       (f_cls),
        .f_xfer      (f_xfer),
        .f_num       (f_num),
        .busy_cycles (rsp_busy_cycles),
        .xfer_words  (rsp_words),
        .rsp_cpa     (rsp_cpa),
        .rsp_cpb     (rsp_cpb)
    );

endmodule

// File: rtl/cpx_handshake_chk.sv
module cpx_handshake_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              issue_valid,
    input logic              cpi_n,
    input logic              in_xfer,
    input logic              line_cpa,
    input logic              line_cpb,
    input logic              irq_pend,
    input logic              rsp_cpa,
    input logic              rsp_cpb,
    input logic              xfer_valid,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              done,
    input logic              trap_undef,
    input logic              interrupted,
    input logic              proto_err
);

    p_issue_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready && issue_valid |=> !cpi_n);

    p_absent_traps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpi_n && !in_xfer && line_cpa && line_cpb |=> trap_undef);

    p_irq_abandons_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpi_n && !in_xfer && !line_cpa && line_cpb && irq_pend |=> interrupted);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && $past(xfer_valid) |-> xfer_addr == $past(xfer_addr) + ADDR_W'(4));

    p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && (!line_cpa || !line_cpb) |=> proto_err);

    p_resp_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpi_n |-> rsp_cpa && rsp_cpb);

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, trap_undef, interrupted, proto_err}));

endmodule

bind cpx_handshake_top cpx_handshake_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .issue_valid (issue_valid),
    .cpi_n       (cpi_n),
    .in_xfer     (in_xfer),
    .line_cpa    (line_cpa),
    .line_cpb    (line_cpb),
    .irq_pend    (irq_pend),
    .rsp_cpa     (rsp_cpa),
    .rsp_cpb     (rsp_cpb),
    .xfer_valid  (xfer_valid),
    .xfer_addr   (xfer_addr),
    .done        (done),
    .trap_undef  (trap_undef),
    .interrupted (interrupted),
    .proto_err   (proto_err)
);

// File: tb/sim_cpx_handshake_top.sv
`timescale 1ns/1ps
module sim_cpx_handshake_top;

    localparam int AW   = 32;
    localparam int CW   = 5;
    localparam int MAXW = 16;
    localparam int CID  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [31:0]   issue_instr = '0;
    logic [AW-1:0] issue_base = '0;
    logic          irq_pend = 1'b0;
    logic          ext_cpa = 1'b1;
    logic          ext_cpb = 1'b1;
    logic [CW-1:0] rsp_busy_cycles = '0;
    logic [CW-1:0] rsp_words = '0;
    logic          ready, cpi_n, xfer_valid, xfer_load;
    logic [AW-1:0] xfer_addr;
    logic          done, trap_undef, interrupted, proto_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cpx_handshake_top #(
        .ADDR_W(AW), .MAX_WORDS(MAXW), .CNT_W(CW), .COP_ID(CID)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_instr(issue_instr), .issue_base(issue_base),
        .irq_pend(irq_pend), .ext_cpa(ext_cpa), .ext_cpb(ext_cpb),
        .rsp_busy_cycles(rsp_busy_cycles), .rsp_words(rsp_words),
        .ready(ready), .cpi_n(cpi_n), .xfer_valid(xfer_valid),
        .xfer_load(xfer_load), .xfer_addr(xfer_addr), .done(done),
        .trap_undef(trap_undef), .interrupted(interrupted),
        .proto_err(proto_err)
    );

    // Reference timeline: c = 0 is the issue cycle, c = fin carries the outcome pulse.
    // kind: 0 done, 1 trap, 2 interrupted, 3 protocol error.
    task automatic run_op(input string tag, input logic [31:0] ins,
                          input logic [31:0] base, input int b, input int w,
                          input int irq_at, input bit extra_issue,
                          input bit cpb_glitch);
        bit hit;
        bit isx;
        int fin;
        int kind;
        int nw;
        logic [6:0]  got;
        logic [6:0]  exp;
        logic [31:0] eaddr;
        bit xv;
        bit bad;
        hit = ins[27] && (ins[11:8] == 4'(CID));
        isx = (ins[27:25] == 3'b110);
        nw  = 0;
        if (cpb_glitch)                        begin fin = 2;         kind = 3; end
        else if (!hit)                         begin fin = 2;         kind = 1; end
        else if (irq_at >= 1 && irq_at <= b)   begin fin = irq_at + 1; kind = 2; end
        else if (!isx)                         begin fin = b + 2;     kind = 0; end
        else if (w <= MAXW)                    begin fin = b + 3 + w; kind = 0; nw = w; end
        else                                   begin fin = b + 3 + MAXW; kind = 3; nw = MAXW; end
        for (int c = 0; c <= fin; c++) begin
            @(negedge clk);
            rsp_busy_cycles = CW'(b);
            rsp_words       = CW'(w);
            issue_valid     = (c == 0) || (extra_issue && c == 1);
            issue_instr     = (c == 0) ? ins : 32'hEC10_0900;
            issue_base      = (c == 0) ? base : 32'hDEAD_0000;
            irq_pend        = (irq_at > 0) && (c >= irq_at);
            ext_cpb         = !(cpb_glitch && c == 1);
            #1;
            xv    = (nw > 0) && (c >= b + 2) && (c < b + 2 + nw);
            eaddr = base + 32'(4 * (c - b - 2));
            got = {ready, cpi_n, xfer_valid, done, trap_undef, interrupted, proto_err};
            exp = {(c == 0 || c == fin), !(c >= 1 && c < fin), xv,
                   (c == fin && kind == 0), (c == fin && kind == 1),
                   (c == fin && kind == 2), (c == fin && kind == 3)};
            bad = (got != exp) || (xv && (xfer_addr != eaddr || xfer_load != ins[20]));
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s cycle %0d: got flags=%b addr=%h load=%b, expected flags=%b addr=%h load=%b",
                         tag, c, got, xfer_addr, xfer_load, exp, eaddr, ins[20]);
            end
        end
        @(negedge clk);
        issue_valid = 1'b0;
        irq_pend    = 1'b0;
        ext_cpb     = 1'b1;
    endtask

    task automatic idle_line_err(input string tag);
        @(negedge clk);
        ext_cpa = 1'b0;
        @(negedge clk);
        ext_cpa = 1'b1;
        #1;
        checks++;
        if (proto_err !== 1'b1 || ready !== 1'b1) begin
            errors++;
            $display("FAIL %s: proto_err=%b ready=%b, expected 1 1", tag, proto_err, ready);
        end
        @(negedge clk);
        #1;
        checks++;
        if (proto_err !== 1'b0) begin
            errors++;
            $display("FAIL %s: proto_err=%b after release, expected 0", tag, proto_err);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        checks++;
        if ({ready, cpi_n, xfer_valid, done, trap_undef, interrupted, proto_err} !== 7'b1100000) begin
            errors++;
            $display("FAIL R1 reset: got %b expected %b",
                     {ready, cpi_n, xfer_valid, done, trap_undef, interrupted, proto_err}, 7'b1100000);
        end
        rst_n = 1'b1;

        // R4 / R2: plain operation, immediate and delayed acceptance
        run_op("R4 plain b=0",  32'hEE00_0900, 32'h0, 0, 0, 0, 1'b0, 1'b0);
        run_op("R2 plain b=3",  32'hEE00_0900, 32'h0, 3, 0, 0, 1'b0, 1'b0);
        // R3 / R9: class-0 instruction with matching number, and a foreign number
        run_op("R9 class0",     32'hE600_0910, 32'h0, 2, 0, 0, 1'b0, 1'b0);
        run_op("R3 foreign",    32'hEE00_0300, 32'h0, 2, 0, 0, 1'b0, 1'b0);
        // R6: load and store transfers, zero and exactly MAX words
        run_op("R6 load w=4",   32'hEC10_0900, 32'h0000_1000, 2, 4, 0, 1'b0, 1'b0);
        run_op("R6 store w=0",  32'hEC00_0900, 32'h0000_2000, 0, 0, 0, 1'b0, 1'b0);
        run_op("R6 store w=16", 32'hEC00_0900, 32'hFFFF_FFF0, 1, 16, 0, 1'b0, 1'b0);
        // R7: coprocessor asks for 20 words
        run_op("R7 overrun",    32'hEC10_0900, 32'h0000_4000, 1, 20, 0, 1'b0, 1'b0);
        // R5: interrupt during busy, restart, interrupt too late
        run_op("R5 irq",        32'hEE00_0900, 32'h0, 5, 0, 2, 1'b0, 1'b0);
        run_op("R5 restart",    32'hEE00_0900, 32'h0, 5, 0, 0, 1'b0, 1'b0);
        run_op("R5 irq late",   32'hEC10_0900, 32'h0000_0100, 3, 2, 4, 1'b0, 1'b0);
        run_op("R5 irq first",  32'hEC10_0900, 32'h0000_0200, 3, 2, 1, 1'b0, 1'b0);
        // R10: issue during handshake is ignored
        run_op("R10 reissue",   32'hEE00_0900, 32'h0, 2, 0, 0, 1'b1, 1'b0);
        run_op("R10 reissue x", 32'hEC00_0900, 32'h0000_0300, 0, 3, 0, 1'b1, 1'b0);
        // R8: lines misbehave while idle and during the wait
        idle_line_err("R8 idle");
        run_op("R8 wait",       32'hE600_0000, 32'h0, 0, 0, 0, 1'b0, 1'b1);
        // R11 covered by one-hot flags in every timeline above
        run_op("R11 final",     32'hEE00_0900, 32'h0, 1, 0, 0, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule